// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block gives an 8-bit CPU a regular timer interrupt, which a multitasking executive uses to switch tasks and keep time. It divides the system clock down to a fixed tick period. At the end of each period it sets a pending request. The request stays set until the CPU acknowledges it.

Software controls the generator by writing command codes to one shared I/O command port. One code starts the ticker and another stops it. After reset the ticker is off, so boot code runs with no tick interrupts until software turns them on. The CPU masks delivery with its own interrupt-disable and interrupt-enable instructions, so the block has no mask of its own. The handler keeps the time counters in memory and chooses the vector; both are outside this block.

Top module: `tick_irq_gen`

## Requirements
- R1: After reset the ticker is disabled and `irq` is 0. `irq` stays 0 for as long as no enable command has been written.
- R2: A write with `io_wr`=1, `io_port`=`CMD_PORT` (default 8'hFE) and `io_data`=20 enables the ticker and restarts the prescaler from zero. The first `irq` rises on the clock edge that comes `PERIOD` edges after the edge that captured the write.
- R3: While the ticker is enabled, ticks occur every `PERIOD` clock cycles. Each tick sets `irq` on that tick's edge.
- R4: A write of code 22 to the command port disables the ticker and clears `irq` on the same edge. No tick occurs until the ticker is enabled again.
- R5: `irq` stays at 1 until an acknowledge or a disable clears it. A tick that arrives while `irq` is already 1 does not queue a second request, so one acknowledge clears it completely.
- R6: The enable state does not change in any of these cases: `io_wr` is 0, the port is not `CMD_PORT`, or the data is any value other than 20 or 22.
- R7: Writing code 20 while the ticker is already enabled restarts the prescaler. The next tick then comes `PERIOD` edges after that write, and no tick occurs on the write's own edge. `irq` is left unchanged.
- R8: On a single edge, a tick takes priority over an acknowledge, so `irq` stays at 1. A disable takes priority over a tick, so `irq` becomes 0.
- R9: `PERIOD` = `CLK_HZ`/`TICK_HZ`. By default this is 64 ticks per second, a 15.625 ms tick. Configurations such as 50 ticks per second are chosen at build time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_port | input | PORT_W | I/O port number of the write |
| io_data | input | DATA_W | Data byte of the write |
| irq | output | 1 | Pending tick interrupt request |
| irq_ack | input | 1 | Acknowledge from the CPU; clears `irq` |

## Verification
The bench sweeps the acknowledge across every phase of the tick period. If a design let the acknowledge beat a coinciding tick, it would lose that tick. If it held the request past an acknowledge, or counted a second request, the next `irq` edge would come at the wrong cycle. A disable is written so that it lands on exactly the edge where a tick is due. A design with the wrong priority would leave `irq` set after being told to stop. An enable is rewritten partway through a period. A design that does not restart the prescaler would fire on the old schedule. Writes to the wrong port, with a neighbouring code, or with the strobe low are also sent. A loose decoder would start or stop the ticker on them.

// File: rtl/tick_pkg.sv
// Package: types shared by the tick interrupt generator.
// Assumes: a single command port carries all ticker commands.
package tick_pkg;

    // Decoded command seen on the I/O bus in one cycle.
    typedef enum logic [1:0] {
        TCMD_NONE  = 2'd0,
        TCMD_START = 2'd1,
        TCMD_STOP  = 2'd2
    } tick_cmd_e;

    // Clock cycles per tick, at least one.
    function automatic int unsigned tick_period(input int unsigned clk_hz,
                                                input int unsigned tick_hz);
        int unsigned p;
        p = clk_hz / tick_hz;
        return (p == 0) ? 1 : p;
    endfunction

endpackage

// File: rtl/tick_cmd_decode.sv
// Module: tick_cmd_decode
// Turns I/O writes into ticker commands. Only a strobed write to CMD_PORT
// that carries START_CODE or STOP_CODE produces a command. Every other write
// decodes to TCMD_NONE.
// Assumes: io_wr is high for exactly one cycle per write.
module tick_cmd_decode
    import tick_pkg::*;
#(
    parameter int unsigned PORT_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CMD_PORT   = 8'hFE,
    parameter int unsigned START_CODE = 20,
    parameter int unsigned STOP_CODE  = 22
) (
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_data,
    output tick_cmd_e         cmd
);
    localparam logic [PORT_W-1:0] PORT_MATCH = PORT_W'(CMD_PORT);
    localparam logic [DATA_W-1:0] START_VAL  = DATA_W'(START_CODE);
    localparam logic [DATA_W-1:0] STOP_VAL   = DATA_W'(STOP_CODE);

    logic hit;

    // Purpose: pick out a write addressed to the command port.
    always_comb begin
        hit = io_wr && (io_port == PORT_MATCH);
    end

    // Purpose: map the data byte to a command; unknown codes do nothing.
    always_comb begin
        cmd = TCMD_NONE;
        if (hit) begin
            if (io_data == START_VAL)     cmd = TCMD_START;
            else if (io_data == STOP_VAL) cmd = TCMD_STOP;
        end
    end
endmodule

// File: rtl/tick_enable.sv
// Module: tick_enable
// Holds the ticker on/off state. A start command sets it and a stop command
// clears it. Reset leaves the ticker off.
// Assumes: start and stop never decode in the same cycle.
module tick_enable
    import tick_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tick_cmd_e cmd,
    output logic      en
);
    // Purpose: update the enable flag from the decoded commands.
    always_ff @(posedge clk) begin
        if (!rst_n)                 en <= 1'b0;
        else if (cmd == TCMD_START) en <= 1'b1;
        else if (cmd == TCMD_STOP)  en <= 1'b0;
    end
endmodule

// File: rtl/tick_prescaler.sv
// Module: tick_prescaler
// Divides the clock by PERIOD. It gives a one-cycle tick on the last count of
// each period. The count is held at zero while disabled, and a restart forces
// it back to zero with no tick on that edge.
// Assumes: PERIOD >= 1.
module tick_prescaler #(
    parameter int unsigned PERIOD = 781250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam int unsigned       CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] count;

    // Purpose: flag the final cycle of a running period.
    always_comb begin
        tick = en && !restart && (count == LAST);
    end

    // Purpose: advance, wrap or clear the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (!en || restart) count <= '0;
        else if (count == LAST) count <= '0;
        else                    count <= count + 1'b1;
    end
endmodule

// File: rtl/tick_pending.sv
// Module: tick_pending
// Holds the interrupt request. A tick sets it; an acknowledge or a stop clears
// it. Priority on one edge: stop, then tick, then acknowledge. A set flag
// absorbs further ticks, so requests never queue.
// Assumes: ack may be held for any number of cycles.
module tick_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    input  logic stop,
    output logic pend
);
    // Purpose: set, hold or clear the request with fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (stop) pend <= 1'b0;
        else if (tick) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end
endmodule

// File: rtl/tick_irq_gen.sv
// Module: tick_irq_gen (top)
// Periodic tick interrupt generator. It decodes start/stop commands from I/O
// writes, divides the clock to the tick rate, and holds a pending request
// until it is acknowledged.
// Assumes: synchronous active-low reset; the CPU masks delivery itself.
module tick_irq_gen
    import tick_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TICK_HZ    = 64,
    parameter int unsigned PORT_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CMD_PORT   = 8'hFE,
    parameter int unsigned START_CODE = 20,
    parameter int unsigned STOP_CODE  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_data,
    output logic              irq,
    input  logic              irq_ack
);
    localparam int unsigned PERIOD = tick_period(CLK_HZ, TICK_HZ);

    tick_cmd_e cmd;
    logic      en;
    logic      start;
    logic      stop;
    logic      tick;

    // Purpose: split the decoded command into single-bit controls.
    always_comb begin
        start = (cmd == TCMD_START);
        stop  = (cmd == TCMD_STOP);
    end

    tick_cmd_decode #(
        .PORT_W(PORT_W), .DATA_W(DATA_W), .CMD_PORT(CMD_PORT),
        .START_CODE(START_CODE), .STOP_CODE(STOP_CODE)
    ) u_dec (
        .io_wr(io_wr), .io_port(io_port), .io_data(io_data), .cmd(cmd)
    );

    tick_enable u_en (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .en(en)
    );

    tick_prescaler #(.PERIOD(PERIOD)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(start), .tick(tick)
    );

    tick_pending u_pend (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ack(irq_ack),
        .stop(stop), .pend(irq)
    );
endmodule

// File: rtl/tick_irq_chk.sv
// Module: tick_irq_chk
// Property checker for tick_irq_gen, bound to every instance. It keeps its own
// cycle counter to check the tick spacing without a long $past.
module tick_irq_chk #(
    parameter int unsigned PERIOD   = 781250,
    parameter int unsigned PORT_W   = 8,
    parameter int unsigned CMD_PORT = 8'hFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [PORT_W-1:0] io_port,
    input logic              irq,
    input logic              irq_ack,
    input logic              en,
    input logic              start,
    input logic              stop,
    input logic              tick
);
    logic [31:0] gap;

    // Purpose: count cycles since the last enable or tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                      gap <= '0;
        else if (start || !en || tick)   gap <= '0;
        else                             gap <= gap + 1'b1;
    end

    a_r1_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);
    a_r2_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> en);
    a_r3_rise_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));
    a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!irq && !en));
    a_r5_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && !stop) |=> irq);
    a_r6_en_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en) |-> $past(io_wr && (io_port == PORT_W'(CMD_PORT))));
    a_r8_tick_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop) |=> irq);
    a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == PERIOD - 1));
endmodule

bind tick_irq_gen tick_irq_chk #(
    .PERIOD(PERIOD), .PORT_W(PORT_W), .CMD_PORT(CMD_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
    .irq(irq), .irq_ack(irq_ack), .en(en), .start(start),
    .stop(stop), .tick(tick)
);

// File: tb/tb_tick_irq_gen.sv
// Bench: small configuration with PERIOD = 640/64 = 10 cycles.
// Inputs are driven and outputs sampled at the falling edge. A cycle-level
// model built from the requirements predicts irq after every edge.
module tb_tick_irq_gen;
    localparam int unsigned P    = 10;
    localparam logic [7:0]  CP   = 8'hFE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_port = '0;
    logic [7:0] io_data = '0;
    logic       irq_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit en_m = 0;
    bit exp_irq = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tick_irq_gen #(.CLK_HZ(640), .TICK_HZ(64)) dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .io_data(io_data), .irq(irq), .irq_ack(irq_ack)
    );

    task automatic check(input string req);
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: irq=%0b expected %0b (k=%0d)", req, irq, exp_irq, k);
        end
    endtask

    // One clock with an optional acknowledge, then model update and check.
    task automatic cyc(input bit ack, input string req);
        bit t;
        irq_ack = ack;
        @(negedge clk);
        irq_ack = 1'b0;
        k++;
        t = en_m && (k % P == 0);
        if (t) exp_irq = 1;
        else if (ack) exp_irq = 0;
        check(req);
    endtask

    // One I/O write, with the model following the command rules.
    task automatic wr(input logic [7:0] p, input logic [7:0] d, input bit strobe,
                      input string req);
        bit t;
        io_wr = strobe; io_port = p; io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (strobe && p == CP && d == 8'd20) begin
            en_m = 1; k = 0;
        end else if (strobe && p == CP && d == 8'd22) begin
            en_m = 0; exp_irq = 0; k++;
        end else begin
            k++;
            t = en_m && (k % P == 0);
            if (t) exp_irq = 1;
        end
        check(req);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset with no enable.
        for (int i = 0; i < 3 * P; i++) cyc(0, "R1");

        // R6: writes that must not enable the ticker.
        wr(8'hFD, 8'd20, 1, "R6");
        wr(CP, 8'd21, 1, "R6");
        wr(CP, 8'd20, 0, "R6");
        wr(CP, 8'd4, 1, "R6");
        for (int i = 0; i < 2 * P; i++) cyc(0, "R6");

        // R2, R3, R5: enable, never acknowledge; request holds, no queueing.
        wr(CP, 8'd20, 1, "R2");
        for (int i = 0; i < 3 * P; i++) cyc(0, "R5");
        cyc(1, "R5");
        for (int i = 0; i < 2 * P; i++) cyc(0, "R3");

        // R3, R8: sweep the acknowledge phase across the whole period.
        for (int ph = 0; ph < int'(P); ph++) begin
            wr(CP, 8'd22, 1, "R4");
            wr(CP, 8'd20, 1, "R2");
            for (int i = 0; i < 4 * P; i++)
                cyc((k + 1) % P == ph && k + 1 > P, ph == 0 ? "R8" : "R3");
        end

        // R6: stray stop-code writes while running leave ticks going.
        wr(8'h00, 8'd22, 1, "R6");
        wr(CP, 8'd22, 0, "R6");
        for (int i = 0; i < 2 * P; i++) cyc(i % 3 == 0, "R6");

        // R7: re-enable mid-period restarts the prescaler.
        for (int i = 0; i < 3; i++) cyc(1, "R7");
        while (k % P != P / 2) cyc(1, "R7");
        wr(CP, 8'd20, 1, "R7");
        for (int i = 0; i < 2 * P; i++) cyc(i % P == 2, "R7");

        // R8: stop lands exactly on a tick edge; irq must end up clear.
        while (k % P != P - 1) cyc(0, "R8");
        wr(CP, 8'd22, 1, "R8");
        // R4: stays silent while off.
        for (int i = 0; i < 3 * P; i++) cyc(0, "R4");

        // R9: tick spacing equals CLK_HZ/TICK_HZ; measure rise to rise.
        wr(CP, 8'd20, 1, "R9");
        begin
            int first = -1;
            int second = -1;
            for (int i = 1; i <= 3 * P; i++) begin
                cyc(irq, "R9");
                if (irq && first < 0) first = i;
                else if (irq && second < 0 && first >= 0) second = i;
            end
            checks++;
            if (first != int'(P) || second - first != int'(P)) begin
                errors++;
                $display("FAIL R9: first=%0d spacing=%0d expected %0d %0d",
                         first, second - first, P, P);
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule